// File: doc/BRIEF.md
# Programmable tap-select binary timer

A 24-stage binary divider clocked by the system clock. A count input is sampled every cycle, and each high-to-low change of that input advances the chain by one. The output pin carries one of the upper sixteen stages, which a 4-bit code selects, so the block works as a divide-by-2^n timer. An inhibit input freezes counting.

A bypass input takes the lowest eight stages out of the chain. Stage 9 then counts input edges directly, and the same codes give ratios from 2 to 2^16. Set and clear inputs force the whole chain to ones or to zeros. Raising bypass, set and clear together selects a test mode in which the chain counts as three separate 8-bit sections. An optional pulse mode replaces the direct tap with a pulse of programmable length in system clocks. The pulse starts on each rising edge of the selected stage.

Top module: `tap_timer`

## Requirements
- R1: With bypass, set, clear and inhibit low, each high-to-low transition of `cnt_in` (seen as 1 in one sampled cycle and 0 in the next) adds one to the 24-bit stage value, which wraps from all ones to zero. No other change of `cnt_in` alters the stages.
- R2: While `inhibit` is high and set and clear are low, the stages hold their value across falling edges of `cnt_in`.
- R3: With `bypass` low and `pulse_mode` low, `tap_out` equals stage 9+k, where k is the value of `sel`. Stage n is bit n-1 of the count, so code k divides the edge rate by 2^(9+k).
- R4: With `bypass` high and not in test mode, each falling edge adds one to stages 9..24 and leaves stages 1..8 unchanged, so code k divides by 2^(k+1).
- R5: `set_in` high with `clr_in` low forces all 24 stages to 1 on the next clock.
- R6: `clr_in` high forces all stages to 0 on the next clock unless test mode is active. This holds also when `set_in` is high and `bypass` is low.
- R7: When `bypass`, `set_in` and `clr_in` are all high, stages 1-8, 9-16 and 17-24 each count falling edges as independent 8-bit counters. From zero, 255 edges make every stage 1.
- R8: When set and clear drop together after test mode has filled the chain, the chain returns to series counting, and one more falling edge takes it from all ones to all zeros.
- R9: With `pulse_mode` high, a rising edge of the selected stage makes `tap_out` high for exactly `pulse_len` system clocks, beginning one clock after the stage rises. A `pulse_len` of 0 gives no pulse.
- R10: `rst_n` low clears all stages and the pulse state, and `tap_out` reads 0 for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 1 | Count input; falling edges advance the chain |
| inhibit | input | 1 | Freeze counting |
| bypass | input | 1 | Skip the lowest eight stages |
| set_in | input | 1 | Force all stages to 1 |
| clr_in | input | 1 | Force all stages to 0 |
| sel | input | 4 | Tap code, stage 9+code |
| pulse_mode | input | 1 | 1: pulse output, 0: direct tap |
| pulse_len | input | 8 | Pulse length in system clocks |
| tap_out | output | 1 | Selected stage or pulse |

## Verification
A wrong stage value is visible at once through the combinational tap: the bench sweeps all sixteen codes after every edge, so a corrupted bit in stages 9 to 24 shows up before the next edge. Faults in the hidden low stages under bypass, or in the carries between test sections, appear only after a later carry crosses into the visible stages. The bench forces such carries on purpose: it leaves bypass with the low byte full, and it counts test mode up to all ones. Pulse faults show as a wrong count of high cycles in a window after a tap edge.

// File: rtl/tap_timer.sv
module tap_timer #(
  parameter int SEC_W = 8,
  parameter int N_SEC = 3,
  parameter int SEL_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_in,
  input  logic             inhibit,
  input  logic             bypass,
  input  logic             set_in,
  input  logic             clr_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             pulse_mode,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             tap_out
);
  localparam int STG = SEC_W * N_SEC;
  localparam int LO  = SEC_W;

  logic             cnt_q, tap_prev;
  logic [STG-1:0]   stg, stg_nxt, sec_inc;
  logic [LEN_W-1:0] pcnt;

  wire fall  = cnt_q & ~cnt_in;
  wire tmode = bypass & set_in & clr_in;
  wire step  = fall & ~inhibit;

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    assign sec_inc[s*SEC_W +: SEC_W] = stg[s*SEC_W +: SEC_W] + 1'b1;
  end

  always_comb begin
    stg_nxt = stg;
    if (tmode) begin
      if (step) stg_nxt = sec_inc;
    end else if (clr_in) begin
      stg_nxt = '0;
    end else if (set_in) begin
      stg_nxt = '1;
    end else if (step) begin
      if (bypass) stg_nxt[STG-1:LO] = stg[STG-1:LO] + 1'b1;
      else        stg_nxt = stg + 1'b1;
    end
  end

  wire tap_sel = stg[LO + int'(sel)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= 1'b0;
      stg      <= '0;
      tap_prev <= 1'b0;
      pcnt     <= '0;
    end else begin
      cnt_q    <= cnt_in;
      stg      <= stg_nxt;
      tap_prev <= tap_sel;
      if (tap_sel & ~tap_prev) pcnt <= pulse_len;
      else if (pcnt != '0)     pcnt <= pcnt - 1'b1;
    end
  end

  assign tap_out = pulse_mode ? (pcnt != '0) : tap_sel;
endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk #(
  parameter int STG = 24,
  parameter int LO  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_q,
  input logic           cnt_in,
  input logic           inhibit,
  input logic           bypass,
  input logic           set_in,
  input logic           clr_in,
  input logic [STG-1:0] stg
);
  a_r1_series_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q && !cnt_in && !inhibit && !bypass && !set_in && !clr_in)
      |=> stg == $past(stg) + 1'b1);
  a_r2_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !set_in && !clr_in) |=> $stable(stg));
  a_r4_low_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !set_in && !clr_in) |=> stg[LO-1:0] == $past(stg[LO-1:0]));
  a_r5_set_all: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && !clr_in) |=> &stg);
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_in && !bypass) |=> stg == '0);
endmodule

bind tap_timer tap_timer_chk #(.STG(STG), .LO(LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_in(cnt_in),
  .inhibit(inhibit), .bypass(bypass), .set_in(set_in), .clr_in(clr_in),
  .stg(stg)
);

// File: tb/test_tap_timer.sv
module test_tap_timer;
  logic clk = 0, rst_n = 0, cnt_in = 1, inhibit = 0, bypass = 0;
  logic set_in = 0, clr_in = 0, pulse_mode = 0;
  logic [3:0] sel = 0;
  logic [7:0] pulse_len = 0;
  logic tap_out;
  logic [23:0] m = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tap_timer i_tap_timer (.clk(clk), .rst_n(rst_n), .cnt_in(cnt_in),
    .inhibit(inhibit), .bypass(bypass), .set_in(set_in), .clr_in(clr_in),
    .sel(sel), .pulse_mode(pulse_mode), .pulse_len(pulse_len), .tap_out(tap_out));

  task automatic chk(string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tap_out=%b expected %b (model %h sel %0d)", rq, act, exp, m, sel);
    end
  endtask

  task automatic sweep(string rq);
    for (int k = 0; k < 16; k++) begin
      sel = k[3:0];
      #0.5;
      chk(rq, tap_out, m[8+k]);
    end
  endtask

  task automatic model_step();
    if (inhibit) return;
    if (bypass && set_in && clr_in)
      for (int s = 0; s < 3; s++) m[s*8 +: 8] = m[s*8 +: 8] + 8'd1;
    else if (bypass) m[23:8] = m[23:8] + 16'd1;
    else m = m + 24'd1;
  endtask

  task automatic do_fall();
    @(negedge clk) cnt_in = 0;
    @(negedge clk) cnt_in = 1;
    model_step();
  endtask

  task automatic pulse_meas(output int n);
    @(negedge clk) cnt_in = 0;
    n = 0;
    repeat (12) @(negedge clk) begin
      if (tap_out) n++;
      cnt_in = 1;
    end
    model_step();
  endtask

  task automatic chk_n(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: pulse cycles=%0d expected %0d", rq, act, exp);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    sweep("R10 reset low");
    rst_n = 1;
    @(negedge clk) sweep("R10 after reset");
    for (int i = 0; i < 700; i++) begin do_fall(); sweep("R1 R3 series count"); end
    inhibit = 1;
    repeat (4) do_fall();
    sweep("R2 inhibit hold");
    inhibit = 0;
    do_fall(); sweep("R2 resume after inhibit");
    @(negedge clk) set_in = 1;
    @(negedge clk) set_in = 0; m = '1;
    sweep("R5 set all ones");
    do_fall(); sweep("R1 wrap to zero");
    @(negedge clk) set_in = 1;
    @(negedge clk) set_in = 0; m = '1;
    @(negedge clk) bypass = 1;
    for (int i = 0; i < 600; i++) begin do_fall(); sweep("R4 bypass count"); end
    @(negedge clk) bypass = 0;
    do_fall(); sweep("R4 low byte held then carries");
    @(negedge clk) begin set_in = 1; clr_in = 1; end
    @(negedge clk) begin set_in = 0; clr_in = 0; end
    m = '0;
    sweep("R6 clear wins over set");
    @(negedge clk) begin bypass = 1; set_in = 1; clr_in = 1; end
    for (int i = 0; i < 255; i++) begin do_fall(); sweep("R7 test sections"); end
    @(negedge clk) begin bypass = 0; set_in = 0; clr_in = 0; end
    sweep("R8 all ones after test");
    do_fall(); sweep("R8 roll to zero");
    pulse_mode = 1; bypass = 1; sel = 0; pulse_len = 5;
    pulse_meas(n); chk_n("R9 pulse len 5", n, 5);
    pulse_meas(n); chk_n("R9 no pulse on tap fall", n, 0);
    pulse_len = 3;
    pulse_meas(n); chk_n("R9 pulse len 3", n, 3);
    pulse_meas(n);
    pulse_len = 0;
    pulse_meas(n); chk_n("R9 pulse len 0", n, 0);
    pulse_mode = 0;
    sweep("R9 direct mode restored");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule